// File: doc/BRIEF.md
# Two-Entry Command Queue Dispatcher

This block takes command bytes written by a host and holds them in a queue with two entries. The entry at the bottom of the queue is executed. Housekeeping commands finish in one cycle. They produce side effects: a pulse that flushes the data buffer, a pulse that resets the device, a timed pulse on the bus reset line, or a reload of the transfer counter. Selection commands are handed to an external sequencer, and the queue holds until the sequencer reports completion. A second command can wait on top while the sequencer works. When the bottom entry is retired, the waiting command drops down and runs.

Three urgent commands skip the queue: device reset, bus reset and DMA stop. Each one empties the queue and takes the bottom slot at once. After a device reset, the command port accepts nothing but a no-op until that no-op has executed. Error conditions are kept as sticky flags: overflow of the queue, an unknown opcode, and a bus reset that raises an interrupt. The interrupt causes are combined into a single request line.

Top module: `cmd_queue_dispatch`

## Requirements
- R1: Bits 6:0 of a command byte are the opcode and bit 7 marks a DMA command. The opcodes are no-op 0x00, flush 0x01, device reset 0x02, bus reset 0x03, DMA stop 0x04, enable selection 0x44, select 0x41 and select with attention 0x42. A command written into an empty, idle queue executes in the cycle after the write edge. Its outputs are visible after the next edge, and at most one command executes per cycle. A flush gives clrFifoPulse high for exactly one cycle.
- R2: A select opcode (0x41 or 0x42) raises seqStart for one cycle, with seqOpcode equal to that opcode. The command stays at the bottom, and nothing else executes until a seqDone pulse arrives.
- R3: While a selection runs, one more command can be queued on top. A write that arrives while both entries are occupied is dropped and sets grossErr. grossErr stays set until a device reset executes.
- R4: On seqDone the bottom entry is removed. A waiting top entry moves down and executes in the following cycle.
- R5: Opcodes 0x02, 0x03 and 0x04 discard every queued entry, abandon a running selection (its seqDone is no longer awaited) and execute next.
- R6: Executing 0x02 gives devRstPulse for one cycle and sets cmdBlocked. While cmdBlocked is set, every write whose opcode is not 0x00 is ignored. An executed no-op clears cmdBlocked.
- R7: A command with bit 7 set loads xferCount when it executes. The full presetCount is loaded when extMode is 1, and only its low 16 bits, zero-extended, when extMode is 0.
- R8: Executing 0x03 holds busRstOut high for exactly CLK_MHZ*RST_US cycles (6250 by default). It also sets intBusReset unless busRstIntDis is 1.
- R9: An opcode not listed in R1 is removed from the queue and sets intInvalidCmd.
- R10: irq is the OR of intInvalidCmd and intBusReset. A cycle with intAck high clears both causes, unless a cause is set in that same cycle.
- R11: After reset, every output is 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command write strobe |
| cmdWrData | input | 8 | Command byte |
| extMode | input | 1 | Extended features: use the full transfer width |
| busRstIntDis | input | 1 | Suppress the bus-reset interrupt cause |
| presetCount | input | XFER_W | Preset transfer count |
| intAck | input | 1 | Clear the interrupt causes |
| seqDone | input | 1 | Sequencer completion pulse |
| seqStart | output | 1 | Start pulse to the sequencer |
| seqOpcode | output | 7 | Opcode handed to the sequencer |
| xferCount | output | XFER_W | Working transfer counter |
| busRstOut | output | 1 | Bus reset line drive |
| clrFifoPulse | output | 1 | Data buffer flush pulse |
| devRstPulse | output | 1 | Device reset pulse |
| grossErr | output | 1 | Queue overflow flag |
| intInvalidCmd | output | 1 | Invalid-command interrupt cause |
| intBusReset | output | 1 | Bus-reset interrupt cause |
| irq | output | 1 | Interrupt request |
| cmdBlocked | output | 1 | Command port blocked after device reset |

## Verification
The assertions check these properties on every cycle:
- No two execution pulses (seqStart, clrFifoPulse, devRstPulse) occur together.
- seqStart never lasts two cycles.
- grossErr only rises right after a write, and is clear whenever a device reset pulses.
- cmdBlocked is set together with devRstPulse.
- The bus-reset cause only appears while the reset line is driven.

Only the directed scenarios can show the rest:
- the queue order and promotion after seqDone;
- the dropped third write;
- the abandoned selection after a bypass command;
- the write filtering while blocked;
- the mode-dependent counter load;
- the exact length of the reset pulse.

// File: rtl/cmd_queue_pkg.sv
package cmd_queue_pkg;

  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_DEV_RST = 7'h02;
  localparam logic [6:0] OP_BUS_RST = 7'h03;
  localparam logic [6:0] OP_DMA_STP = 7'h04;
  localparam logic [6:0] OP_SEL     = 7'h41;
  localparam logic [6:0] OP_SEL_ATN = 7'h42;
  localparam logic [6:0] OP_EN_SEL  = 7'h44;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBottom;
    logic loadTop;
    logic shift;
    logic loadXfer;
    logic startBusRst;
  } qStrobes_t;

  function automatic logic isBypass(input logic [6:0] op);
    return (op == OP_DEV_RST) || (op == OP_BUS_RST) || (op == OP_DMA_STP);
  endfunction

  function automatic logic isSelect(input logic [6:0] op);
    return (op == OP_SEL) || (op == OP_SEL_ATN);
  endfunction

  function automatic logic isSimple(input logic [6:0] op);
    return (op == OP_NOP) || (op == OP_FLUSH) || (op == OP_EN_SEL) || isBypass(op);
  endfunction

endpackage

// File: rtl/cmd_queue_dp.sv
module cmd_queue_dp
  import cmd_queue_pkg::*;
#(
  parameter int XFER_W     = 24,
  parameter int STD_W      = 16,
  parameter int RST_CYCLES = 6250
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobes_t         strb,
  input  logic [7:0]        cmdByte,
  input  logic              extMode,
  input  logic [XFER_W-1:0] presetCount,
  output logic [7:0]        bottomCmd,
  output logic [XFER_W-1:0] xferCount,
  output logic              busRstOut
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [7:0]        slot0, slot1;
  logic [CNT_W-1:0]  rstCnt;
  logic [XFER_W-1:0] stdCount;

  generate
    if (XFER_W > STD_W) begin : g_pad
      assign stdCount = {{(XFER_W-STD_W){1'b0}}, presetCount[STD_W-1:0]};
    end else begin : g_full
      assign stdCount = presetCount;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot0 <= '0;
      slot1 <= '0;
    end else begin
      if (strb.loadBottom)  slot0 <= cmdByte;
      else if (strb.shift)  slot0 <= slot1;
      if (strb.loadTop)     slot1 <= cmdByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              xferCount <= '0;
    else if (strb.loadXfer) xferCount <= extMode ? presetCount : stdCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rstCnt <= '0;
    else if (strb.startBusRst) rstCnt <= CNT_W'(RST_CYCLES);
    else if (rstCnt != '0)     rstCnt <= rstCnt - 1'b1;
  end

  assign busRstOut = (rstCnt != '0);
  assign bottomCmd = slot0;

endmodule

// File: rtl/cmd_queue_ctrl.sv
module cmd_queue_ctrl
  import cmd_queue_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic [7:0] cmdByte,
  input  logic [7:0] bottomCmd,
  input  logic       seqDone,
  input  logic       busRstIntDis,
  input  logic       intAck,
  output qStrobes_t  strb,
  output logic       seqStart,
  output logic [6:0] seqOpcode,
  output logic       clrFifoPulse,
  output logic       devRstPulse,
  output logic       grossErr,
  output logic       intInvalidCmd,
  output logic       intBusReset,
  output logic       cmdBlocked
);

  logic [1:0] slotValid;
  logic       running;
  logic [6:0] botOp, wrOp;
  logic       execNow, botIsSel, botKnown, execDevRst;
  logic       wrAccept, wrBypass, wrNormal, doPop;
  logic       afterPop0, afterPop1, overflow;

  assign botOp      = bottomCmd[6:0];
  assign wrOp       = cmdByte[6:0];
  assign execNow    = slotValid[0] && !running;
  assign botIsSel   = isSelect(botOp);
  assign botKnown   = botIsSel || isSimple(botOp);
  assign execDevRst = execNow && (botOp == OP_DEV_RST);

  // blocked port takes only a no-op; a device reset executing now drops the write
  assign wrAccept = cmdWr && (!cmdBlocked || (wrOp == OP_NOP)) && !execDevRst;
  assign wrBypass = wrAccept && isBypass(wrOp);
  assign wrNormal = wrAccept && !isBypass(wrOp);

  assign doPop     = (execNow && !botIsSel) || (running && seqDone);
  assign afterPop0 = doPop ? slotValid[1] : slotValid[0];
  assign afterPop1 = doPop ? 1'b0 : slotValid[1];
  assign overflow  = wrNormal && afterPop0 && afterPop1;

  always_comb begin
    strb             = '0;
    strb.shift       = doPop;
    strb.loadBottom  = wrBypass || (wrNormal && !afterPop0);
    strb.loadTop     = wrNormal && afterPop0 && !afterPop1 && !wrBypass;
    strb.loadXfer    = execNow && bottomCmd[7];
    strb.startBusRst = execNow && (botOp == OP_BUS_RST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      running   <= 1'b0;
    end else if (execDevRst) begin
      slotValid <= '0;
      running   <= 1'b0;
    end else if (wrBypass) begin
      slotValid <= 2'b01;
      running   <= 1'b0;
    end else begin
      slotValid <= {afterPop1 | strb.loadTop, afterPop0 | strb.loadBottom};
      if (execNow && botIsSel) running <= 1'b1;
      else if (seqDone)        running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBlocked    <= 1'b0;
      grossErr      <= 1'b0;
      seqStart      <= 1'b0;
      seqOpcode     <= '0;
      clrFifoPulse  <= 1'b0;
      devRstPulse   <= 1'b0;
      intInvalidCmd <= 1'b0;
      intBusReset   <= 1'b0;
    end else begin
      if (execDevRst)                          cmdBlocked <= 1'b1;
      else if (execNow && (botOp == OP_NOP))   cmdBlocked <= 1'b0;
      grossErr      <= execDevRst ? 1'b0 : (grossErr | overflow);
      seqStart      <= execNow && botIsSel && !wrBypass;
      if (execNow && botIsSel) seqOpcode <= botOp;
      clrFifoPulse  <= execNow && (botOp == OP_FLUSH);
      devRstPulse   <= execDevRst;
      intInvalidCmd <= (execNow && !botKnown) || (intInvalidCmd && !intAck);
      intBusReset   <= (strb.startBusRst && !busRstIntDis) || (intBusReset && !intAck);
    end
  end

endmodule

// File: rtl/cmd_queue_dispatch.sv
module cmd_queue_dispatch
  import cmd_queue_pkg::*;
#(
  parameter int XFER_W  = 24,
  parameter int STD_W   = 16,
  parameter int CLK_MHZ = 250,
  parameter int RST_US  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [7:0]        cmdWrData,
  input  logic              extMode,
  input  logic              busRstIntDis,
  input  logic [XFER_W-1:0] presetCount,
  input  logic              intAck,
  input  logic              seqDone,
  output logic              seqStart,
  output logic [6:0]        seqOpcode,
  output logic [XFER_W-1:0] xferCount,
  output logic              busRstOut,
  output logic              clrFifoPulse,
  output logic              devRstPulse,
  output logic              grossErr,
  output logic              intInvalidCmd,
  output logic              intBusReset,
  output logic              irq,
  output logic              cmdBlocked
);

  localparam int RST_CYCLES = CLK_MHZ * RST_US;

  qStrobes_t  strb;
  logic [7:0] bottomCmd;

  cmd_queue_ctrl i_ctrl (
    .clk, .rstN, .cmdWr,
    .cmdByte(cmdWrData),
    .bottomCmd, .seqDone, .busRstIntDis, .intAck,
    .strb, .seqStart, .seqOpcode, .clrFifoPulse, .devRstPulse,
    .grossErr, .intInvalidCmd, .intBusReset, .cmdBlocked
  );

  cmd_queue_dp #(
    .XFER_W(XFER_W), .STD_W(STD_W), .RST_CYCLES(RST_CYCLES)
  ) i_dp (
    .clk, .rstN, .strb,
    .cmdByte(cmdWrData),
    .extMode, .presetCount, .bottomCmd, .xferCount, .busRstOut
  );

  assign irq = intInvalidCmd | intBusReset;

endmodule

// File: rtl/cmd_queue_checker.sv
module cmd_queue_checker (
  input logic clk,
  input logic rstN,
  input logic cmdWr,
  input logic seqStart,
  input logic clrFifoPulse,
  input logic devRstPulse,
  input logic grossErr,
  input logic cmdBlocked,
  input logic intBusReset,
  input logic busRstOut
);

  a_r1_one_exec: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({seqStart, clrFifoPulse, devRstPulse}));

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> !seqStart);

  a_r3_err_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grossErr) |-> $past(cmdWr));

  a_r3_err_cleared: assert property (@(posedge clk) disable iff (!rstN)
    devRstPulse |-> !grossErr);

  a_r6_reset_blocks: assert property (@(posedge clk) disable iff (!rstN)
    devRstPulse |-> cmdBlocked);

  a_r8_rst_line: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intBusReset) |-> busRstOut);

endmodule

bind cmd_queue_dispatch cmd_queue_checker i_chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .seqStart(seqStart),
  .clrFifoPulse(clrFifoPulse), .devRstPulse(devRstPulse), .grossErr(grossErr),
  .cmdBlocked(cmdBlocked), .intBusReset(intBusReset), .busRstOut(busRstOut)
);

// File: tb/test_cmd_queue_dispatch.sv
module test_cmd_queue_dispatch;

  localparam int RST_LEN = 250 * 25;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic [7:0]  cmdWrData = '0;
  logic        extMode = 1'b0;
  logic        busRstIntDis = 1'b0;
  logic [23:0] presetCount = '0;
  logic        intAck = 1'b0;
  logic        seqDone = 1'b0;
  logic        seqStart, busRstOut, clrFifoPulse, devRstPulse, grossErr;
  logic        intInvalidCmd, intBusReset, irq, cmdBlocked;
  logic [6:0]  seqOpcode;
  logic [23:0] xferCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmd_queue_dispatch i_cmd_queue_dispatch (
    .clk, .rstN, .cmdWr, .cmdWrData, .extMode, .busRstIntDis, .presetCount,
    .intAck, .seqDone, .seqStart, .seqOpcode, .xferCount, .busRstOut,
    .clrFifoPulse, .devRstPulse, .grossErr, .intInvalidCmd, .intBusReset,
    .irq, .cmdBlocked
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // write lands at the edge after the first negedge; returns just after that edge
  task automatic wr(input logic [7:0] b);
    @(negedge clk); cmdWr = 1'b1; cmdWrData = b;
    @(negedge clk); cmdWr = 1'b0;
  endtask

  task automatic doneTick();
    @(negedge clk); seqDone = 1'b1;
    @(negedge clk); seqDone = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, {clrFifoPulse, seqStart}, 2'b00);
    end
  endtask

  task automatic t_reset();
    chk("R11 outputs", {seqStart, busRstOut, clrFifoPulse, devRstPulse, grossErr,
        intInvalidCmd, intBusReset, irq, cmdBlocked}, '0);
    chk("R11 xferCount", xferCount, 0);
  endtask

  task automatic t_flush();
    wr(8'h01);
    @(negedge clk); chk("R1 flush pulse", clrFifoPulse, 1);
    @(negedge clk); chk("R1 flush one cycle", clrFifoPulse, 0);
  endtask

  task automatic t_select_queue();
    wr(8'h41);
    @(negedge clk); chk("R2 seqStart", seqStart, 1); chk("R2 seqOpcode", seqOpcode, 7'h41);
    @(negedge clk); chk("R2 seqStart one cycle", seqStart, 0);
    wr(8'h01);
    quiet(3, "R2 held while running");
    doneTick();
    @(negedge clk); chk("R4 promoted runs", clrFifoPulse, 1);
  endtask

  task automatic t_overflow();
    wr(8'h41);
    @(negedge clk); chk("R2 start", seqStart, 1);
    wr(8'h42);
    chk("R3 no error at two", grossErr, 0);
    wr(8'h01);
    chk("R3 overflow error", grossErr, 1);
    doneTick();
    @(negedge clk); chk("R4 second select", seqStart, 1); chk("R4 opcode", seqOpcode, 7'h42);
    doneTick();
    quiet(3, "R3 dropped write");
    chk("R3 error sticky", grossErr, 1);
  endtask

  task automatic t_bypass();
    wr(8'h41);
    @(negedge clk); chk("R5 start", seqStart, 1);
    wr(8'h01);
    wr(8'h04);
    quiet(3, "R5 queue emptied");
    wr(8'h01);
    @(negedge clk); chk("R5 no wait for done", clrFifoPulse, 1);
  endtask

  task automatic t_dma();
    presetCount = 24'hABCDEF; extMode = 1'b0;
    wr(8'h80);
    @(negedge clk); chk("R7 std width", xferCount, 24'h00CDEF);
    extMode = 1'b1;
    wr(8'h81);
    @(negedge clk); chk("R7 ext width", xferCount, 24'hABCDEF);
    chk("R7 dma flush runs", clrFifoPulse, 1);
    presetCount = 24'h123456;
    wr(8'h01);
    @(negedge clk); chk("R7 no load without dma bit", xferCount, 24'hABCDEF);
  endtask

  task automatic t_invalid();
    wr(8'h7F);
    @(negedge clk); chk("R9 invalid cause", intInvalidCmd, 1); chk("R10 irq", irq, 1);
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    chk("R10 ack clears", {intInvalidCmd, irq}, 2'b00);
  endtask

  task automatic t_busrst();
    int n;
    busRstIntDis = 1'b1;
    wr(8'h03);
    @(negedge clk); chk("R8 line high", busRstOut, 1); chk("R8 masked cause", intBusReset, 0);
    n = 0;
    while (busRstOut && n < RST_LEN + 10) begin n++; @(negedge clk); end
    chk("R8 pulse length", n, RST_LEN);
    busRstIntDis = 1'b0;
    wr(8'h03);
    @(negedge clk); chk("R8 cause set", intBusReset, 1); chk("R10 irq bus", irq, 1);
    n = 0;
    while (busRstOut && n < RST_LEN + 10) begin n++; @(negedge clk); end
    intAck = 1'b1; @(negedge clk); intAck = 1'b0;
    chk("R10 bus cause cleared", intBusReset, 0);
  endtask

  task automatic t_devrst();
    wr(8'h02);
    @(negedge clk); chk("R6 reset pulse", devRstPulse, 1); chk("R6 blocked", cmdBlocked, 1);
    chk("R3 error cleared", grossErr, 0);
    wr(8'h01);
    quiet(3, "R6 flush ignored");
    wr(8'h41);
    quiet(3, "R6 select ignored");
    wr(8'h00);
    @(negedge clk); chk("R6 nop unblocks", cmdBlocked, 0);
    wr(8'h01);
    @(negedge clk); chk("R6 accepts again", clrFifoPulse, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_flush();
    t_select_queue();
    t_overflow();
    t_bypass();
    t_dma();
    t_invalid();
    t_busrst();
    t_devrst();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule